// File: doc/BRIEF.md
# Two-Step Armed Watchdog Timer

This block is a down-counting watchdog. A slow time-base strobe of 16 Hz drives the count. Software has to take two separate steps before the timer accepts a reload. First it arms the timer with a rising edge on an arming bit of the control register. Then it reloads the timer with a rising edge on a reload bit. The reload takes the high nibble of the count from a 4-bit preset field and fills the low nibble with ones, so the timeout runs from about one to sixteen seconds. If no reload arrives in time, the block raises a sticky interrupt. One tick later it pulses the processor reset for one tick and then returns to its stopped, unarmed state. While the power converter is off, counting pauses.

The block carries no data stream, so it has no valid/ready interface. Each pin is a plain level or strobe. The control register is written through a single-cycle write strobe and the byte that goes with it. An edge on a bit means that the stored bit was 0 and the new write sets it to 1. Control register layout:
- bit 7 is the arming bit.
- bits 6..3 are the preset field.
- bit 2 is the reload bit.
- the remaining bits are stored and have no function.

Top module: `wdog_armed_timer`

## Requirements
- R1: After reset the block is stopped and unarmed, with `irq` = 0 and `wd_rst` = 0.
- R2: While stopped, ticks do nothing. No number of ticks raises `irq` or `wd_rst` until an accepted reload.
- R3: A write that takes control bit 7 from 0 to 1 arms the timer. Arming is cancelled when the timer expires.
- R4: A write that takes control bit 2 from 0 to 1 while armed is accepted. The count becomes {bits 6..3 of that write, 4'b1111}, the timer runs, and the arm is used up. An arming edge in the same write does not qualify that write's reload.
- R5: A reload edge while unarmed is ignored. A running count continues and still expires on schedule.
- R6: While running, the count drops by one on each tick with `pwr_on` = 1. With `pwr_on` = 0 the count holds.
- R7: `irq` sets on the tick that brings the count to 1. With preset P that is 16·P+14 ticks after the reload, which is 254 ticks for P = 15.
- R8: `wd_rst` rises on the next counting tick, when the count reaches 0, which is one tick after `irq`. It falls on the following tick, and the block is then stopped and unarmed.
- R9: `irq` stays set until an `irq_clr` pulse clears it. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| tick | input | 1 | One-cycle 16 Hz time-base strobe |
| pwr_on | input | 1 | Power converter on; 0 suspends counting |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq | output | 1 | Sticky expiry-warning interrupt |
| wd_rst | output | 1 | Processor reset pulse, one tick long |

## Verification
The hardest case to reach is an unarmed reload that lands in the middle of a live count. The earlier write has left both control bits high, so the stimulus must first write zero to clear the stored bits. Only then can it write the reload bit alone, which produces a genuine rising edge with no arm behind it. The bench then counts ticks to `irq` and expects the original schedule of 14 ticks in total for preset 0. A further sequence raises both bits in one write, shows that nothing loads, and then reloads using that write's arm. The full-scale preset is driven to confirm the 254/255 tick boundary.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  parameter int CTRL_W     = 8;
  parameter int ARM_BIT    = 7;
  parameter int LOAD_BIT   = 2;
  parameter int PRESET_LSB = 3;
endpackage

// File: rtl/wdt_arm_ctrl.sv
module wdt_arm_ctrl #(
  parameter int PRESET_W = 4,
  parameter int LOW_W    = 4,
  localparam int CNT_W   = PRESET_W + LOW_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [wdt_pkg::CTRL_W-1:0] wdata,
  input  logic                       expire,
  output logic                       load_ok,
  output logic [CNT_W-1:0]           load_val,
  output logic                       armed_q
);
  import wdt_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] rise;

  // per-bit rising-edge detection against the stored register
  for (genvar i = 0; i < CTRL_W; i++) begin : g_rise
    assign rise[i] = we & wdata[i] & ~ctrl_q[i];
  end

  assign load_ok  = rise[LOAD_BIT] & armed_q;
  assign load_val = {wdata[PRESET_LSB +: PRESET_W], {LOW_W{1'b1}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (we) ctrl_q <= wdata;
      if (expire)             armed_q <= 1'b0;
      else if (rise[ARM_BIT]) armed_q <= 1'b1;
      else if (load_ok)       armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pwr_on,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             expire,
  output logic             step,
  output logic [CNT_W-1:0] count,
  output logic             running
);
  assign step = running & pwr_on & tick & ~load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (load) begin
      count   <= load_val;
      running <= 1'b1;
    end else if (step) begin
      count <= count - 1'b1;
      if (expire) running <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_alarm.sv
module wdt_alarm #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             step,
  input  logic [CNT_W-1:0] count,
  input  logic             irq_clr,
  output logic             expire,
  output logic             irq,
  output logic             wd_rst
);
  localparam logic [CNT_W-1:0] WARN_AT = CNT_W'(2);
  localparam logic [CNT_W-1:0] LAST_AT = CNT_W'(1);

  logic warn;
  assign warn   = step & (count == WARN_AT);
  assign expire = step & (count == LAST_AT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      wd_rst <= 1'b0;
    end else begin
      if (warn)         irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
      if (expire)             wd_rst <= 1'b1;
      else if (tick & wd_rst) wd_rst <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_armed_timer.sv
module wdog_armed_timer #(
  parameter int PRESET_W = 4,
  parameter int LOW_W    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  input  logic       tick,
  input  logic       pwr_on,
  input  logic       irq_clr,
  output logic       irq,
  output logic       wd_rst
);
  localparam int CNT_W = PRESET_W + LOW_W;

  logic             load_ok;
  logic [CNT_W-1:0] load_val;
  logic             armed_q;
  logic             expire;
  logic             step;
  logic [CNT_W-1:0] count;
  logic             running;

  wdt_arm_ctrl #(.PRESET_W(PRESET_W), .LOW_W(LOW_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata),
    .expire(expire), .load_ok(load_ok), .load_val(load_val), .armed_q(armed_q)
  );

  wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_on(pwr_on),
    .load(load_ok), .load_val(load_val), .expire(expire),
    .step(step), .count(count), .running(running)
  );

  wdt_alarm #(.CNT_W(CNT_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step(step), .count(count),
    .irq_clr(irq_clr), .expire(expire), .irq(irq), .wd_rst(wd_rst)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             pwr_on,
  input logic             irq_clr,
  input logic             irq,
  input logic             wd_rst,
  input logic [CNT_W-1:0] count,
  input logic             running,
  input logic             load_ok,
  input logic [CNT_W-1:0] load_val,
  input logic             armed_q
);
  p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> (running && count == $past(load_val)));

  p_arm_needed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !load_ok && running && !pwr_on) |=> count == $past(count));

  p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !pwr_on && !load_ok) |=> count == $past(count));

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pwr_on && tick && !load_ok) |=> count == $past(count) - 1'b1);

  p_irq_at_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> count == CNT_W'(1));

  p_rst_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst) |-> (count == '0 && !running && !armed_q));

  p_rst_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_rst && !tick) |=> wd_rst);

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  p_stopped_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load_ok) |=> !$rose(irq));
endmodule

bind wdog_armed_timer wdt_checker #(.CNT_W(PRESET_W + LOW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_on(pwr_on), .irq_clr(irq_clr),
  .irq(irq), .wd_rst(wd_rst), .count(count), .running(running),
  .load_ok(load_ok), .load_val(load_val), .armed_q(armed_q)
);

// File: tb/tb_wdog_armed_timer.sv
module tb_wdog_armed_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic tick = 1'b0;
  logic pwr_on = 1'b1;
  logic irq_clr = 1'b0;
  logic irq, wd_rst;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  wdog_armed_timer dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .tick(tick), .pwr_on(pwr_on), .irq_clr(irq_clr), .irq(irq), .wd_rst(wd_rst)
  );

  // behavioural reference model
  logic [7:0] m_reg, m_rise;
  int  m_cnt;
  bit  m_run, m_arm, m_irq, m_rst, m_ld, m_stp;
  bit  n_irq, n_rst, n_arm;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 8'h00; m_cnt = 0; m_run = 0; m_arm = 0; m_irq = 0; m_rst = 0;
    end else begin
      m_rise = ctrl_we ? (ctrl_wdata & ~m_reg) : 8'h00;
      m_ld   = m_rise[2] && m_arm;
      m_stp  = m_run && pwr_on && tick && !m_ld;
      n_irq = m_irq;
      if (irq_clr) n_irq = 0;
      if (m_stp && m_cnt == 2) n_irq = 1;
      n_rst = m_rst;
      if (m_rst && tick) n_rst = 0;
      if (m_stp && m_cnt == 1) n_rst = 1;
      n_arm = m_arm;
      if (m_ld) n_arm = 0;
      if (m_rise[7]) n_arm = 1;
      if (m_stp && m_cnt == 1) n_arm = 0;
      if (m_ld) begin
        m_cnt = 16 * int'(ctrl_wdata[6:3]) + 15;
        m_run = 1;
      end else if (m_stp) begin
        if (m_cnt == 1) m_run = 0;
        m_cnt = m_cnt - 1;
      end
      if (ctrl_we) m_reg = ctrl_wdata;
      m_irq = n_irq; m_rst = n_rst; m_arm = n_arm;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks += 2;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R7 R9 irq per-cycle: actual=%0b expected=%0b t=%0t", irq, m_irq, $time);
      end
      if (wd_rst !== m_rst) begin
        errors++;
        $display("FAIL R8 wd_rst per-cycle: actual=%0b expected=%0b t=%0t", wd_rst, m_rst, $time);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick_once();
  endtask

  task automatic until_irq(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      tick_once();
      if (irq) begin n = i; break; end
    end
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic finish_expiry(input string tag);
    tick_once();
    chk({tag, " R8 wd_rst one tick after irq"}, int'(wd_rst), 1);
    tick_once();
    chk({tag, " R8 wd_rst released next tick"}, int'(wd_rst), 0);
    clr_irq();
    chk({tag, " R9 irq cleared"}, int'(irq), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 wd_rst after reset", int'(wd_rst), 0);

    ticks(20);
    chk("R2 no irq while stopped", int'(irq), 0);

    wr(8'h04);
    ticks(300);
    chk("R2 R5 unarmed reload from stop ignored", int'(irq) + int'(wd_rst), 0);

    // preset 1 -> 30 ticks to irq
    wr(8'h00); wr(8'h80); wr(8'h8C);
    until_irq(100, n);
    chk("R3 R4 R7 ticks to irq preset 1", n, 30);
    tick_once();
    chk("R8 wd_rst after irq", int'(wd_rst), 1);
    tick_once();
    chk("R8 wd_rst one tick wide", int'(wd_rst), 0);
    ticks(40);
    chk("R8 stopped after expiry", int'(wd_rst), 0);
    chk("R9 irq sticky", int'(irq), 1);
    clr_irq();
    chk("R9 irq cleared", int'(irq), 0);

    // unarmed reload mid-count
    wr(8'h00); wr(8'h80); wr(8'h84);
    ticks(5);
    wr(8'h00); wr(8'h04);
    until_irq(100, n);
    chk("R5 unarmed reload keeps schedule", n, 9);
    finish_expiry("R5");

    // armed reload restarts
    wr(8'h00); wr(8'h80); wr(8'h84);
    ticks(10);
    wr(8'h00); wr(8'h80); wr(8'h84);
    until_irq(100, n);
    chk("R3 R4 armed reload restarts", n, 14);
    finish_expiry("R4");

    // power converter off
    wr(8'h00); wr(8'h80); wr(8'h84);
    pwr_on = 1'b0;
    ticks(30);
    chk("R6 no count while power off", int'(irq), 0);
    pwr_on = 1'b1;
    until_irq(100, n);
    chk("R6 full count after power on", n, 14);
    finish_expiry("R6");

    // arm and reload in one write
    wr(8'h00); wr(8'h84);
    ticks(40);
    chk("R4 same-write arm does not load", int'(irq), 0);
    wr(8'h80); wr(8'h84);
    until_irq(100, n);
    chk("R4 reload with earlier-write arm", n, 14);
    finish_expiry("R4b");

    // full-scale preset
    wr(8'h00); wr(8'h80); wr(8'hFC);
    until_irq(300, n);
    chk("R7 max ticks to irq", n, 254);
    finish_expiry("R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule